// File: doc/BRIEF.md
# Split Dual 8-bit Auto-Reload Timer

This block is a timer peripheral that runs permanently as two independent 8-bit up-counters, a high half and a low half. Each half owns an 8-bit reload register. When a half counts past its all-ones value, it reloads from that register and sets a sticky overflow flag. Software can write either counter directly and can clear either flag.

Each half picks its own tick rate. It can tick on every system clock cycle, once every 12 system clock cycles, or once every 8 rising edges of an external clock. The external clock is asynchronous. It is brought into the system clock domain through a two-flop synchroniser and an edge detector, so every tick is a single-cycle enable in one clock domain. The high half counts only while its run bit is set. The low half always counts.

A level interrupt request combines the two flags. The high flag always contributes. The low flag contributes only when its own enable bit is set. A global enable gates the whole request.

Top module: `split_reload_timer`

## Requirements
- R1: When a half's fast-select bit is 1, its counter advances by one on every system clock cycle in which it is allowed to count.
- R2: When a half counts while holding 0xFF, the next value is that half's reload value, with no pass through 0x00. The same tick sets the half's overflow flag.
- R3: The high counter changes only while `run_hi` is 1 or when software writes it. The low counter counts whatever the value of `run_hi`.
- R4: When fast-select is 0 and `ext_sel` is 0, the half advances exactly once every 12 system clock cycles.
- R5: When fast-select is 0 and `ext_sel` is 1, the half advances once for every 8 rising edges of `ext_clk`, counted after synchronisation. A steady `ext_clk` gives no advance.
- R6: An overflow flag stays at 1 until its clear input is pulsed. Clearing one flag leaves the other flag unchanged.
- R7: `irq` = `irq_en` AND (`flag_hi` OR (`flag_lo` AND `lo_irq_en`)). It is a level output with no clock delay.
- R8: A counter write in the same cycle as a tick loads the written value exactly, and that cycle neither increments the counter nor sets its flag.
- R9: When an overflow of a half and a clear of that half's flag occur in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously; deasserts in step with clk |
| ext_clk | input | 1 | Asynchronous external clock |
| run_hi | input | 1 | Run control for the high half |
| hi_fast | input | 1 | High half ticks on every clock when 1 |
| lo_fast | input | 1 | Low half ticks on every clock when 1 |
| ext_sel | input | 1 | For a half that is not fast: 0 selects clock/12, 1 selects external/8 |
| irq_en | input | 1 | Global interrupt enable |
| lo_irq_en | input | 1 | Lets the low flag take part in `irq` |
| reload_hi | input | 8 | Reload value for the high half |
| reload_lo | input | 8 | Reload value for the low half |
| cnt_hi_wr | input | 1 | Write strobe for the high counter |
| cnt_hi_wdata | input | 8 | Write data for the high counter |
| cnt_lo_wr | input | 1 | Write strobe for the low counter |
| cnt_lo_wdata | input | 8 | Write data for the low counter |
| clr_hi | input | 1 | Clears the high overflow flag |
| clr_lo | input | 1 | Clears the low overflow flag |
| cnt_hi | output | 8 | High counter value |
| cnt_lo | output | 8 | Low counter value |
| flag_hi | output | 1 | Sticky high overflow flag |
| flag_lo | output | 1 | Sticky low overflow flag |
| irq | output | 1 | Combined interrupt request level |

## Verification
Two pairs of events can fall in the same cycle. A software write can meet a counting tick, and a software flag clear can meet a hardware overflow. The bench produces each collision by asserting the write or clear strobe on the same falling edge that turns on the fast tick for a counter. For the flag case, that counter already holds 0xFF. The check expects the exact written value with no increment, then a single increment one cycle later. For the flag case, it expects the flag to read 1 after the colliding edge.

// File: rtl/srt_pkg.sv
package srt_pkg;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_SYS  = 2'd2
  } tick_src_e;

  function automatic tick_src_e pick_src(input logic fast, input logic ext_sel);
    if (fast)         return SRC_SYS;
    else if (ext_sel) return SRC_EXT;
    else              return SRC_SLOW;
  endfunction

endpackage

// File: rtl/srt_tickgen.sv
module srt_tickgen #(
  parameter int SLOW_DIV    = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic slow_tick,
  output logic ext_tick
);

  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);
  localparam logic [EW-1:0] EXT_LAST  = EW'(EXT_DIV - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic [SW-1:0]          slow_q, slow_d;
  logic [EW-1:0]          ecnt_q, ecnt_d;
  logic                   ext_rise;

  // synchroniser shift, edge detect, and both dividers
  always_comb begin
    sync_d    = {sync_q[SYNC_STAGES-2:0], ext_clk};
    prev_d    = sync_q[SYNC_STAGES-1];
    ext_rise  = sync_q[SYNC_STAGES-1] & ~prev_q;

    slow_tick = (slow_q == SLOW_LAST);
    slow_d    = slow_tick ? '0 : slow_q + 1'b1;

    ext_tick  = ext_rise && (ecnt_q == EXT_LAST);
    ecnt_d    = ecnt_q;
    if (ext_rise) ecnt_d = (ecnt_q == EXT_LAST) ? '0 : ecnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      slow_q <= '0;
      ecnt_q <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      slow_q <= slow_d;
      ecnt_q <= ecnt_d;
    end
  end

  // R4: the slow tick is a single-cycle pulse
  p_slow_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |=> !slow_tick);

  // R5: an external tick needs a fresh synchronised rising edge
  p_ext_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |-> (sync_q[SYNC_STAGES-1] && !prev_q));

endmodule

// File: rtl/srt_half.sv
module srt_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] reload,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         flag
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         flag_q, flag_d;
  logic         count_en;
  logic         wrap;

  always_comb begin
    count_en = tick & ~wr;
    wrap     = count_en && (cnt_q == TOP);

    cnt_d = cnt_q;
    if (wr)            cnt_d = wdata;
    else if (wrap)     cnt_d = reload;
    else if (count_en) cnt_d = cnt_q + 1'b1;

    flag_d = flag_q;
    if (wrap)     flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

  p_write_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt_q == $past(wdata)));

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && cnt_q == TOP) |=> (cnt_q == $past(reload)) && flag_q);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && cnt_q == TOP && clr) |=> flag_q);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> $stable(cnt_q));

endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer #(
  parameter int W           = 8,
  parameter int SLOW_DIV    = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_clk,
  input  logic         run_hi,
  input  logic         hi_fast,
  input  logic         lo_fast,
  input  logic         ext_sel,
  input  logic         irq_en,
  input  logic         lo_irq_en,
  input  logic [W-1:0] reload_hi,
  input  logic [W-1:0] reload_lo,
  input  logic         cnt_hi_wr,
  input  logic [W-1:0] cnt_hi_wdata,
  input  logic         cnt_lo_wr,
  input  logic [W-1:0] cnt_lo_wdata,
  input  logic         clr_hi,
  input  logic         clr_lo,
  output logic [W-1:0] cnt_hi,
  output logic [W-1:0] cnt_lo,
  output logic         flag_hi,
  output logic         flag_lo,
  output logic         irq
);
  import srt_pkg::*;

  localparam int NH = 2;  // index 0 = low half, 1 = high half

  logic slow_tick, ext_tick;

  logic [NH-1:0] fast_sel, run_en, tick_en, wr_v, clr_v, flag_v;
  logic [W-1:0]  wdata_v  [NH];
  logic [W-1:0]  reload_v [NH];
  logic [W-1:0]  cnt_v    [NH];

  srt_tickgen #(
    .SLOW_DIV   (SLOW_DIV),
    .EXT_DIV    (EXT_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_clk  (ext_clk),
    .slow_tick(slow_tick),
    .ext_tick (ext_tick)
  );

  always_comb begin
    fast_sel    = {hi_fast, lo_fast};
    run_en      = {run_hi, 1'b1};
    wr_v        = {cnt_hi_wr, cnt_lo_wr};
    clr_v       = {clr_hi, clr_lo};
    wdata_v[0]  = cnt_lo_wdata;
    wdata_v[1]  = cnt_hi_wdata;
    reload_v[0] = reload_lo;
    reload_v[1] = reload_hi;
  end

  for (genvar g = 0; g < NH; g++) begin : g_half
    tick_src_e src;
    logic      raw_tick;

    always_comb begin
      src = pick_src(fast_sel[g], ext_sel);
      unique case (src)
        SRC_SYS:  raw_tick = 1'b1;
        SRC_EXT:  raw_tick = ext_tick;
        default:  raw_tick = slow_tick;
      endcase
      tick_en[g] = raw_tick & run_en[g];
    end

    srt_half #(.W(W)) u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_en[g]),
      .wr    (wr_v[g]),
      .wdata (wdata_v[g]),
      .reload(reload_v[g]),
      .clr   (clr_v[g]),
      .cnt   (cnt_v[g]),
      .flag  (flag_v[g])
    );
  end

  assign cnt_lo  = cnt_v[0];
  assign cnt_hi  = cnt_v[1];
  assign flag_lo = flag_v[0];
  assign flag_hi = flag_v[1];
  assign irq     = irq_en & (flag_hi | (flag_lo & lo_irq_en));

  p_run_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_hi && !cnt_hi_wr) |=> $stable(cnt_hi));

  p_fast_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_fast && !cnt_lo_wr && cnt_lo != '1) |=> (cnt_lo == $past(cnt_lo) + 1'b1));

  p_irq_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && flag_hi) |-> irq);

  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

endmodule

// File: tb/sim_split_reload_timer.sv
`timescale 1ns/1ps
module sim_split_reload_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_clk, run_hi, hi_fast, lo_fast, ext_sel, irq_en, lo_irq_en;
  logic [7:0] reload_hi, reload_lo, cnt_hi_wdata, cnt_lo_wdata;
  logic       cnt_hi_wr, cnt_lo_wr, clr_hi, clr_lo;
  logic [7:0] cnt_hi, cnt_lo;
  logic       flag_hi, flag_lo, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  split_reload_timer u0 (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .run_hi(run_hi),
    .hi_fast(hi_fast), .lo_fast(lo_fast), .ext_sel(ext_sel),
    .irq_en(irq_en), .lo_irq_en(lo_irq_en),
    .reload_hi(reload_hi), .reload_lo(reload_lo),
    .cnt_hi_wr(cnt_hi_wr), .cnt_hi_wdata(cnt_hi_wdata),
    .cnt_lo_wr(cnt_lo_wr), .cnt_lo_wdata(cnt_lo_wdata),
    .clr_hi(clr_hi), .clr_lo(clr_lo),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .flag_hi(flag_hi), .flag_lo(flag_lo),
    .irq(irq)
  );

  // {hi_ovf, lo_ovf, irq_en, lo_irq_en, expected irq}
  localparam logic [4:0] VEC [8] = '{
    5'b1_0_1_0_1, 5'b0_1_1_0_0, 5'b0_1_1_1_1, 5'b1_0_0_1_0,
    5'b1_1_0_1_0, 5'b0_0_1_1_0, 5'b1_1_1_1_1, 5'b0_1_0_0_0
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cnt(input bit hi, input logic [7:0] v);
    @(negedge clk);
    if (hi) begin cnt_hi_wr = 1; cnt_hi_wdata = v; end
    else    begin cnt_lo_wr = 1; cnt_lo_wdata = v; end
    @(negedge clk);
    cnt_hi_wr = 0; cnt_lo_wr = 0;
  endtask

  task automatic fast_ticks(input bit hi, input int n);
    if (hi) hi_fast = 1; else lo_fast = 1;
    repeat (n) @(negedge clk);
    hi_fast = 0; lo_fast = 0;
  endtask

  task automatic clear_flags();
    clr_hi = 1; clr_lo = 1;
    @(negedge clk);
    clr_hi = 0; clr_lo = 0;
  endtask

  initial begin
    logic [7:0] base;
    int waited;
    rst_n = 0; ext_clk = 0; run_hi = 0; hi_fast = 0; lo_fast = 0; ext_sel = 1;
    irq_en = 0; lo_irq_en = 0; reload_hi = 8'h40; reload_lo = 8'h20;
    cnt_hi_wr = 0; cnt_lo_wr = 0; cnt_hi_wdata = 0; cnt_lo_wdata = 0;
    clr_hi = 0; clr_lo = 0;
    repeat (3) @(negedge clk);
    chk("reset cnt_hi", cnt_hi, 0);
    chk("reset cnt_lo", cnt_lo, 0);
    chk("reset flags", {flag_hi, flag_lo}, 0);
    chk("reset irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R5: 16 synchronised rising edges -> +2 on the low half, steady ext -> none
    for (int i = 0; i < 16; i++) begin
      ext_clk = 1; repeat (2) @(negedge clk);
      ext_clk = 0; repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk("R5 ext/8 low count", cnt_lo, 2);
    chk("R3 high held with run off", cnt_hi, 0);
    repeat (20) @(negedge clk);
    chk("R5 steady ext no tick", cnt_lo, 2);

    // table of interrupt combinations (R7)
    run_hi = 1;
    for (int v = 0; v < 8; v++) begin
      irq_en = 0; lo_irq_en = 0;
      clear_flags();
      if (VEC[v][4]) begin wr_cnt(1, 8'hFF); fast_ticks(1, 1); end
      if (VEC[v][3]) begin wr_cnt(0, 8'hFF); fast_ticks(0, 1); end
      irq_en = VEC[v][2]; lo_irq_en = VEC[v][1];
      #1;
      chk($sformatf("R7 irq vector %0d", v), irq, VEC[v][0]);
      chk($sformatf("R2 flags vector %0d", v), {flag_hi, flag_lo}, VEC[v][4:3]);
    end
    irq_en = 0; lo_irq_en = 0;
    clear_flags();

    // R1: fast counting
    wr_cnt(1, 8'h10);
    fast_ticks(1, 5);
    chk("R1 fast count high", cnt_hi, 8'h15);

    // R2: reload instead of passing through zero
    wr_cnt(0, 8'hFE);
    fast_ticks(0, 1);
    chk("R2 at FF", cnt_lo, 8'hFF);
    chk("R2 no flag before wrap", flag_lo, 0);
    fast_ticks(0, 1);
    chk("R2 reload value", cnt_lo, 8'h20);
    chk("R2 flag set", flag_lo, 1);

    // R6: sticky and independent clear
    wr_cnt(1, 8'hFF); fast_ticks(1, 1);
    repeat (10) @(negedge clk);
    chk("R6 flags stay set", {flag_hi, flag_lo}, 2'b11);
    clr_lo = 1; @(negedge clk); clr_lo = 0;
    chk("R6 only low cleared", {flag_hi, flag_lo}, 2'b10);

    // R3: run off gates high only
    run_hi = 0;
    wr_cnt(1, 8'h05); wr_cnt(0, 8'h05);
    hi_fast = 1; lo_fast = 1;
    repeat (4) @(negedge clk);
    hi_fast = 0; lo_fast = 0;
    chk("R3 high frozen", cnt_hi, 8'h05);
    chk("R3 low counts", cnt_lo, 8'h09);
    run_hi = 1;

    // R8: write collides with tick
    hi_fast = 1; cnt_hi_wr = 1; cnt_hi_wdata = 8'h33;
    @(negedge clk);
    cnt_hi_wr = 0;
    chk("R8 write wins", cnt_hi, 8'h33);
    @(negedge clk);
    hi_fast = 0;
    chk("R8 count resumes", cnt_hi, 8'h34);
    wr_cnt(0, 8'hFF);
    clear_flags();
    lo_fast = 1; cnt_lo_wr = 1; cnt_lo_wdata = 8'h00;
    @(negedge clk);
    cnt_lo_wr = 0; lo_fast = 0;
    chk("R8 write at FF, no flag", {flag_lo, cnt_lo}, 9'h000);

    // R9: set wins over clear
    wr_cnt(1, 8'hFF);
    hi_fast = 1; clr_hi = 1;
    @(negedge clk);
    hi_fast = 0; clr_hi = 0;
    chk("R9 set beats clear", flag_hi, 1);
    chk("R9 reloaded", cnt_hi, 8'h40);

    // R4: divide by 12 on the low half
    run_hi = 0; ext_sel = 0;
    base = cnt_lo; waited = 0;
    while (cnt_lo == base && waited < 30) begin @(negedge clk); waited++; end
    base = cnt_lo;
    repeat (11) @(negedge clk);
    chk("R4 no tick within 11", cnt_lo, base);
    @(negedge clk);
    chk("R4 tick at 12", cnt_lo, 8'(base + 1));
    ext_sel = 1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule